// File: doc/BRIEF.md
# Conditional Branch Resolve Unit

This unit resolves one 24-bit conditional branch instruction per strobe. The fetch stage hands it the three instruction bytes (`in_b0` from PC, `in_b1` from PC+1, `in_b2` from PC+2), the address of the instruction and the values of the two source registers. The register file read happens outside the unit. The unit works out which branch form the bytes encode, evaluates the condition and computes where fetch continues.

The supported forms are compare to zero, compare with a signed constant, compare with an unsigned constant, register-register compares and single-bit tests. The constants come from two fixed 16-entry tables. Encodings that share the same opcode space but are not conditional branches are flagged as unsupported and never reported taken. All results are registered. They appear one clock after the strobe and hold until the next strobe.

Top module: `branch_resolve`

## Requirements
- R1: While reset is active, and until the first strobe after reset, `out_valid`, `out_taken` and `out_unsupported` are 0 and `out_next_pc` is 0.
- R2: A result appears on the outputs in the clock cycle after `in_valid` was high, and `out_valid` is high for exactly that cycle. While `in_valid` is low, `out_taken`, `out_unsupported` and `out_next_pc` keep their values.
- R3: When the branch is not taken, including the unsupported case, `out_next_pc` equals the instruction address plus 3.
- R4: When the branch is taken, `out_next_pc` equals the instruction address plus 4 plus a sign-extended offset. In the zero-compare form the offset is 12 bits, {b1[3:0], b2}, sign-extended from bit 11. In all other forms the offset is b2, sign-extended from bit 7.
- R5: Zero compare is major code b0[7:4]=6 with group b0[3:2]=1. Mode b0[1:0] selects the test on the s operand: 0 means equal to 0, 1 means not equal to 0, 2 means signed less than 0, and 3 means signed greater than or equal to 0.
- R6: Signed-constant compare is b0[7:4]=6 with b0[3:2]=2. It uses the same four modes as R5, applied against the constant chosen by b1[3:0] from the table {all ones, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256} (index 0 first).
- R7: Unsigned-constant compare is b0[7:4]=6 with b0[3:2]=3. Mode 2 tests unsigned s < constant and mode 3 tests unsigned s >= constant. The constant is chosen by b1[3:0] from {32768, 65536, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256}.
- R8: The register form is b0[7:4]=7, with function field f=b1[3:0], where f[3] inverts the test. The plain tests selected by f[2:0] are: 0, (s AND t)==0; 1, s==t; 2, signed s<t; 3, unsigned s<t; 4, (s AND t)==t.
- R9: In the register form, f[2:0]=5 branches when bit t[4:0] of s is 0. With f[3]=1 it branches when that bit is 1.
- R10: In the register form, f[2:0]=6 or 7 tests the bit of s with index {f[0], b0[3:0]}. It branches when that bit is 0, or when it is 1 with f[3]=1.
- R11: Every other encoding raises `out_unsupported` and drives `out_taken` to 0. This covers any b0[7:4] other than 6 or 7, b0[7:4]=6 with b0[3:2]=0, and b0[3:2]=3 with mode 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe: resolve the instruction on the inputs |
| in_b0 | input | 8 | Instruction byte at PC |
| in_b1 | input | 8 | Instruction byte at PC+1 |
| in_b2 | input | 8 | Instruction byte at PC+2 |
| in_pc | input | PC_W | Address of the instruction |
| in_s_val | input | DATA_W | Value of the first source register |
| in_t_val | input | DATA_W | Value of the second source register |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_taken | output | 1 | Branch taken |
| out_unsupported | output | 1 | Encoding is not a supported conditional branch |
| out_next_pc | output | PC_W | Next fetch address |

## Verification
Two functions share a single cycle in two places. First, in the immediate bit tests the same function nibble both chooses the high bit of the index and inverts the sense. Second, in the unsupported encodings the operand values alone would often satisfy a condition, yet the result must still be not-taken with the fall-through address. The bench provokes both by drawing random function nibbles and random operands, and it forces operand patterns at 0x80000000, 0x7FFFFFFF, all ones and exact table constants. Offsets are pushed to their largest positive and negative values. A reference function in the bench judges every response field against the taken flag, the unsupported flag and the next address.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [2:0] {
    FORM_NONE   = 3'd0,
    FORM_ZERO   = 3'd1,
    FORM_SCONST = 3'd2,
    FORM_UCONST = 3'd3,
    FORM_REG    = 3'd4
  } form_e;

  // signed-compare constant set
  function automatic logic [31:0] signed_const(input logic [3:0] idx);
    logic [31:0] v;
    case (idx)
      4'd0:    v = 32'hFFFF_FFFF;
      4'd9:    v = 32'd10;
      4'd10:   v = 32'd12;
      4'd11:   v = 32'd16;
      4'd12:   v = 32'd32;
      4'd13:   v = 32'd64;
      4'd14:   v = 32'd128;
      4'd15:   v = 32'd256;
      default: v = {28'd0, idx};
    endcase
    return v;
  endfunction

  // unsigned-compare constant set: differs only in the first two slots
  function automatic logic [31:0] unsigned_const(input logic [3:0] idx);
    logic [31:0] v;
    case (idx)
      4'd0:    v = 32'd32768;
      4'd1:    v = 32'd65536;
      default: v = signed_const(idx);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [7:0]      b0,
  input  logic [7:0]      b1,
  input  logic [7:0]      b2,
  output form_e           form,
  output logic [1:0]      mode,
  output logic [3:0]      func,
  output logic [3:0]      tfield,
  output logic [PC_W-1:0] offset,
  output logic            unsupported
);

  localparam int EXT12 = PC_W - 12;
  localparam int EXT8  = PC_W - 8;

  logic [3:0] major;
  logic [1:0] group;
  logic       unused_sreg_field;

  assign major  = b0[7:4];
  assign group  = b0[3:2];
  assign mode   = b0[1:0];
  assign tfield = b0[3:0];
  assign func   = b1[3:0];
  // register specifier nibble: operands arrive on ports
  assign unused_sreg_field = ^b1[7:4];

  always_comb begin
    form = FORM_NONE;
    if (major == 4'd6) begin
      case (group)
        2'd1:    form = FORM_ZERO;
        2'd2:    form = FORM_SCONST;
        2'd3:    form = mode[1] ? FORM_UCONST : FORM_NONE;
        default: form = FORM_NONE;
      endcase
    end else if (major == 4'd7) begin
      form = FORM_REG;
    end
  end

  assign unsupported = (form == FORM_NONE);

  always_comb begin
    if (form == FORM_ZERO)
      offset = {{EXT12{b1[3]}}, b1[3:0], b2};
    else
      offset = {{EXT8{b2[7]}}, b2};
  end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  form_e             form,
  input  logic [1:0]        mode,
  input  logic [3:0]        func,
  input  logic [3:0]        tfield,
  input  logic [DATA_W-1:0] s_val,
  input  logic [DATA_W-1:0] t_val,
  output logic              cond
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] imm_rhs;
  logic              imm_eq;
  logic              imm_lt;
  logic              imm_ltu;
  logic              reg_base;
  logic [IDX_W-1:0]  reg_bit_idx;
  logic [IDX_W-1:0]  imm_bit_idx;

  always_comb begin
    case (form)
      FORM_SCONST: imm_rhs = DATA_W'(signed_const(func));
      FORM_UCONST: imm_rhs = DATA_W'(unsigned_const(func));
      default:     imm_rhs = '0;
    endcase
  end

  assign imm_eq  = (s_val == imm_rhs);
  assign imm_lt  = ($signed(s_val) < $signed(imm_rhs));
  assign imm_ltu = (s_val < imm_rhs);

  assign reg_bit_idx = t_val[IDX_W-1:0];
  assign imm_bit_idx = IDX_W'({func[0], tfield});

  always_comb begin
    case (func[2:0])
      3'd0:    reg_base = ((s_val & t_val) == '0);
      3'd1:    reg_base = (s_val == t_val);
      3'd2:    reg_base = ($signed(s_val) < $signed(t_val));
      3'd3:    reg_base = (s_val < t_val);
      3'd4:    reg_base = ((s_val & t_val) == t_val);
      3'd5:    reg_base = ~s_val[reg_bit_idx];
      default: reg_base = ~s_val[imm_bit_idx];
    endcase
  end

  always_comb begin
    case (form)
      FORM_ZERO,
      FORM_SCONST: cond = (mode[1] ? imm_lt : imm_eq) ^ mode[0];
      FORM_UCONST: cond = imm_ltu ^ mode[0];
      FORM_REG:    cond = reg_base ^ func[3];
      default:     cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] offset,
  input  logic            take,
  output logic [PC_W-1:0] next_pc
);

  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(3);
  localparam logic [PC_W-1:0] TGT_BASE = PC_W'(4);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] tgt_pc;

  assign seq_pc  = pc + SEQ_STEP;
  assign tgt_pc  = pc + TGT_BASE + offset;
  assign next_pc = take ? tgt_pc : seq_pc;

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import bru_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_b0,
  input  logic [7:0]        in_b1,
  input  logic [7:0]        in_b2,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [DATA_W-1:0] in_s_val,
  input  logic [DATA_W-1:0] in_t_val,
  output logic              out_valid,
  output logic              out_taken,
  output logic              out_unsupported,
  output logic [PC_W-1:0]   out_next_pc
);

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  form_e           form;
  logic [1:0]      mode;
  logic [3:0]      func;
  logic [3:0]      tfield;
  logic [PC_W-1:0] offset;
  logic            unsup_c;
  logic            cond_c;
  logic            take_c;
  logic [PC_W-1:0] next_pc_c;

  bru_decode #(.PC_W(PC_W)) u_decode (
    .b0(in_b0), .b1(in_b1), .b2(in_b2),
    .form(form), .mode(mode), .func(func), .tfield(tfield),
    .offset(offset), .unsupported(unsup_c)
  );

  bru_cond #(.DATA_W(DATA_W)) u_cond (
    .form(form), .mode(mode), .func(func), .tfield(tfield),
    .s_val(in_s_val), .t_val(in_t_val), .cond(cond_c)
  );

  assign take_c = cond_c & ~unsup_c;

  bru_target #(.PC_W(PC_W)) u_target (
    .pc(in_pc), .offset(offset), .take(take_c), .next_pc(next_pc_c)
  );

  // next-state
  logic            valid_d, taken_d, unsup_d;
  logic [PC_W-1:0] npc_d;
  logic            valid_q, taken_q, unsup_q;
  logic [PC_W-1:0] npc_q;

  always_comb begin
    valid_d = in_valid;
    taken_d = taken_q;
    unsup_d = unsup_q;
    npc_d   = npc_q;
    if (in_valid) begin
      taken_d = take_c;
      unsup_d = unsup_c;
      npc_d   = next_pc_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      unsup_q <= 1'b0;
      npc_q   <= '0;
    end else begin
      valid_q <= valid_d;
      taken_q <= taken_d;
      unsup_q <= unsup_d;
      npc_q   <= npc_d;
    end
  end

  assign out_valid       = valid_q;
  assign out_taken       = taken_q;
  assign out_unsupported = unsup_q;
  assign out_next_pc     = npc_q;

  AST_UNSUP_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_unsupported |-> !out_taken); // R11

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_taken) && $stable(out_next_pc) && $stable(out_unsupported))); // R2

  AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !take_c) |=> (out_next_pc == $past(in_pc) + PC_W'(3))); // R3

endmodule

// File: tb/branch_resolve_test.sv
module branch_resolve_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_b0, in_b1, in_b2;
  logic [31:0] in_pc, in_s_val, in_t_val;
  logic        out_valid, out_taken, out_unsupported;
  logic [31:0] out_next_pc;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  branch_resolve uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_b0(in_b0), .in_b1(in_b1), .in_b2(in_b2), .in_pc(in_pc),
    .in_s_val(in_s_val), .in_t_val(in_t_val),
    .out_valid(out_valid), .out_taken(out_taken),
    .out_unsupported(out_unsupported), .out_next_pc(out_next_pc)
  );

  logic [31:0] tbl_s [16] = '{32'hFFFFFFFF, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256};
  logic [31:0] tbl_u [16] = '{32768, 65536, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256};
  logic [31:0] edge_vals [6] = '{32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h1, 32'h10000};

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void ref_eval(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                                   input logic [31:0] pc, input logic [31:0] s, input logic [31:0] t,
                                   output logic tk, output logic un, output logic [31:0] np,
                                   output string req);
    logic [3:0]  op0;
    logic [1:0]  grp, m;
    logic [3:0]  f;
    logic [31:0] c;
    logic [31:0] off;
    op0 = b0[7:4]; grp = b0[3:2]; m = b0[1:0]; f = b1[3:0];
    tk = 1'b0; un = 1'b0; req = "R11";
    if (op0 == 4'd6 && grp == 2'd1) begin
      req = "R5";
      case (m)
        2'd0: tk = (s == 0);
        2'd1: tk = (s != 0);
        2'd2: tk = s[31];
        default: tk = !s[31];
      endcase
    end else if (op0 == 4'd6 && grp == 2'd2) begin
      req = "R6"; c = tbl_s[f];
      case (m)
        2'd0: tk = (s == c);
        2'd1: tk = (s != c);
        2'd2: tk = ($signed(s) < $signed(c));
        default: tk = ($signed(s) >= $signed(c));
      endcase
    end else if (op0 == 4'd6 && grp == 2'd3 && m >= 2) begin
      req = "R7"; c = tbl_u[f];
      tk = (m == 2) ? (s < c) : (s >= c);
    end else if (op0 == 4'd7) begin
      req = (f[2:0] == 5) ? "R9" : (f[2:0] >= 6) ? "R10" : "R8";
      case (f)
        4'd0:  tk = ((s & t) == 0);
        4'd8:  tk = ((s & t) != 0);
        4'd1:  tk = (s == t);
        4'd9:  tk = (s != t);
        4'd2:  tk = ($signed(s) < $signed(t));
        4'd10: tk = ($signed(s) >= $signed(t));
        4'd3:  tk = (s < t);
        4'd11: tk = (s >= t);
        4'd4:  tk = ((s & t) == t);
        4'd12: tk = ((s & t) != t);
        4'd5:  tk = !s[t % 32];
        4'd13: tk = s[t % 32];
        4'd6:  tk = !s[b0[3:0]];
        4'd7:  tk = !s[16 + b0[3:0]];
        4'd14: tk = s[b0[3:0]];
        default: tk = s[16 + b0[3:0]];
      endcase
    end else begin
      un = 1'b1;
    end
    if (op0 == 4'd6 && grp == 2'd1) off = {{20{b1[3]}}, b1[3:0], b2};
    else off = {{24{b2[7]}}, b2};
    np = tk ? pc + 32'd4 + off : pc + 32'd3;
  endfunction

  task automatic run_one(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input logic [31:0] pc, input logic [31:0] s, input logic [31:0] t);
    logic tk, un;
    logic [31:0] np, held;
    string req;
    ref_eval(b0, b1, b2, pc, s, t, tk, un, np, req);
    @(negedge clk);
    in_b0 = b0; in_b1 = b1; in_b2 = b2; in_pc = pc; in_s_val = s; in_t_val = t;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_b0 = ~b0; in_s_val = ~s;
    check("R2", "valid", {31'd0, out_valid}, 32'd1);
    check(req, "taken", {31'd0, out_taken}, {31'd0, tk});
    check(un ? "R11" : req, "unsupported", {31'd0, out_unsupported}, {31'd0, un});
    check(tk ? "R4" : "R3", "next_pc", out_next_pc, np);
    held = out_next_pc;
    @(negedge clk);
    check("R2", "valid low", {31'd0, out_valid}, 32'd0);
    check("R2", "held pc", out_next_pc, held);
  endtask

  function automatic logic [31:0] pick_val();
    if ($urandom_range(3) == 0) return edge_vals[$urandom_range(5)];
    return $urandom();
  endfunction

  initial begin : watchdog
    #(20 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; in_valid = 1'b0;
    in_b0 = 0; in_b1 = 0; in_b2 = 0; in_pc = 0; in_s_val = 0; in_t_val = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "valid", {31'd0, out_valid}, 0);
    check("R1", "taken", {31'd0, out_taken}, 0);
    check("R1", "unsupported", {31'd0, out_unsupported}, 0);
    check("R1", "next_pc", out_next_pc, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "next_pc after release", out_next_pc, 0);

    // directed: R5 extremes of the 12-bit offset
    run_one(8'h64, 8'h07, 8'hFF, 32'h1000, 32'h0, 32'h0);          // max positive
    run_one(8'h64, 8'h08, 8'h00, 32'h1000, 32'h0, 32'h0);          // max negative
    run_one(8'h66, 8'h00, 8'h10, 32'h2000, 32'h80000000, 32'h0);   // LTZ on min
    run_one(8'h67, 8'h00, 8'h10, 32'h2000, 32'h7FFFFFFF, 32'h0);   // GEZ on max
    // R6 all-ones constant, R7 first slots
    run_one(8'h68, 8'h00, 8'h7F, 32'h3000, 32'hFFFFFFFF, 32'h0);
    run_one(8'h6A, 8'h00, 8'h80, 32'h3000, 32'h80000000, 32'h0);
    run_one(8'h6E, 8'h00, 8'h05, 32'h4000, 32'h7FFF, 32'h0);
    run_one(8'h6F, 8'h01, 8'h05, 32'h4000, 32'h10000, 32'h0);
    // R8..R10
    run_one(8'h70, 8'h04, 8'h20, 32'h5000, 32'hF0F0, 32'hF000);
    run_one(8'h70, 8'h02, 8'h20, 32'h5000, 32'h80000000, 32'h7FFFFFFF);
    run_one(8'h70, 8'h05, 8'hF0, 32'h5000, 32'h7FFFFFFF, 32'h3F);
    run_one(8'h7F, 8'h07, 8'h80, 32'h5000, 32'h80000000, 32'h0);
    run_one(8'h7F, 8'h0E, 8'h80, 32'h5000, 32'h00008000, 32'h0);
    // R11 unsupported with conditions that would hold
    run_one(8'h60, 8'h00, 8'h10, 32'h6000, 32'h0, 32'h0);
    run_one(8'h6C, 8'h00, 8'h10, 32'h6000, 32'h0, 32'h0);
    run_one(8'h50, 8'h00, 8'h10, 32'h6000, 32'h0, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b0, b1, b2;
      logic [31:0] s, t;
      b0 = $urandom();
      case ($urandom_range(7))
        0:       ;
        1, 2, 3: b0[7:4] = 4'd6;
        default: b0[7:4] = 4'd7;
      endcase
      b1 = $urandom(); b2 = $urandom();
      s = pick_val(); t = pick_val();
      if (b0[7:4] == 4'd6 && $urandom_range(3) == 0)
        s = (b0[3:2] == 2'd3) ? tbl_u[b1[3:0]] : tbl_s[b1[3:0]];
      if (b0[7:4] == 4'd7 && $urandom_range(4) == 0) t = s;
      run_one(b0, b1, b2, $urandom(), s, t);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule